// File: doc/BRIEF.md
# Configurable General-Purpose I/O Port

This block is an eight-pin general-purpose I/O port. Three registers hold its setup: a data latch, a direction mask and an option mask. Bit N of each register belongs to pin N. Clearing a direction bit makes the pin an input, and the option bit then picks one of two inputs. The first is a plain floating input. The second has its pull-up turned on and joins the port's interrupt group. Setting a direction bit makes the pin an output, and the option bit then picks push-pull or open-drain drive. For each pin the block drives three pad controls (output enable, output value, pull-up enable) and reads back the pad level.

On-chip peripherals can take over any pin through override inputs, and an override always beats the register setup. The pins in the interrupt group are sampled through a two-flop synchronizer and combined by AND into one group level. A two-bit mode input sets the sensitivity on that level: low level, falling edge, rising edge, or both edges. The result is a single registered request line.

Top module: `gpio_port`

## Requirements
- R1: After reset all three registers read 0, every pin is a floating input (pad_oe and pad_pu all 0), and irq_req is 0.
- R2: The register address selects the data latch (0), the direction mask (1) or the option mask (2). A read returns the selected value in the same cycle through rd_data. A write with wr_en takes effect at the clock edge. Address 3 reads as 0 and a write to it changes nothing.
- R3: A pin whose direction bit is 0 is never driven (pad_oe bit 0). Reading address 0 returns the live pad_in level for that pin. A write to address 0 changes only the latch: the pad stays undriven, and the value appears on the pad once the pin is switched to output.
- R4: A pin with direction 1 and option 0 is push-pull: pad_oe is 1 and pad_out equals the latch bit. Reading address 0 returns the latch bit, not the pad level.
- R5: A pin with direction 1 and option 1 is open-drain. Latch 0 gives pad_oe 1 with pad_out 0. Latch 1 gives pad_oe 0, so the pin floats. pad_out is never 1 in this mode.
- R6: pad_pu is 1 only on a pin with direction 0 and option 1. An input with option 0 floats, and output pins never have the pull-up on.
- R7: When alt_out_en is 1 on a pin, that pin drives alt_out_val whatever the registers hold. alt_out_od 0 gives push-pull (pad_oe 1, pad_out = alt_out_val). alt_out_od 1 gives open-drain (pad_oe = NOT alt_out_val, pad_out 0). pad_pu is 0. alt_out_en wins over alt_in_en.
- R8: When alt_in_en is 1 on a pin and alt_out_en is 0, that pin is a floating input (pad_oe 0, pad_pu 0) whatever the registers hold. Reading address 0 returns pad_in for that pin.
- R9: The interrupt group is every pin with direction 0 and option 1. The group level is the AND of the synchronized pad levels of those pins, so one group pin held low hides activity on the others. Output pins are not in the group. With no pin in the group, irq_req stays 0.
- R10: With irq_mode 0 (low level), irq_req is 1 while the group level is low. It rises on the third rising clock edge after a pad change and stays high while the level stays low.
- R11: irq_mode 1 (falling), 2 (rising) and 3 (both) give a one-cycle irq_req pulse on the matching change of the group level. The pulse starts on the third rising edge after the pad change.
- R12: While any group pin has alt_in_en or alt_out_en set, irq_req is 0 from the next clock edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| pad_in | input | 8 | Level seen at each pad |
| pad_oe | output | 8 | Pad output enable |
| pad_out | output | 8 | Pad output value |
| pad_pu | output | 8 | Pad pull-up enable |
| alt_out_en | input | 8 | Peripheral drives the pin |
| alt_out_val | input | 8 | Value the peripheral drives |
| alt_out_od | input | 8 | Peripheral asks for open-drain drive |
| alt_in_en | input | 8 | Peripheral receives from the pin |
| irq_mode | input | 2 | Group sensitivity: 0 low, 1 fall, 2 rise, 3 both |
| irq_req | output | 1 | Grouped interrupt request |

## Verification
The pin controls are tested with every direction/option pairing and with the latch at both values. A read of address 0 is compared against a pad level chosen to differ from the latch, which shows whether the live pin or the stored bit is returned. The interrupt group is tested with one pin low and the other pins moving: a falling edge on a second pin must not raise a request, which shows the group is combined by AND and not by OR. Each sensitivity mode is run on the same edge sequence, and the request is sampled one cycle after the expected pulse, which separates a pulse from a level. An override is applied to a group pin while a low-level request is active, and the request must drop.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [1:0] {
        IRQ_LOW  = 2'd0,
        IRQ_FALL = 2'd1,
        IRQ_RISE = 2'd2,
        IRQ_BOTH = 2'd3
    } irq_mode_e;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_DIR  = 2'd1;
    localparam logic [1:0] ADDR_OPT  = 2'd2;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs #(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [N_PINS-1:0] wr_data,
    output logic [N_PINS-1:0] latch,
    output logic [N_PINS-1:0] dir,
    output logic [N_PINS-1:0] opt
);
    import gpio_pkg::*;

    typedef struct packed {
        logic [N_PINS-1:0] latch;
        logic [N_PINS-1:0] dir;
        logic [N_PINS-1:0] opt;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (addr)
                ADDR_DATA: st_d.latch = wr_data;
                ADDR_DIR:  st_d.dir   = wr_data;
                ADDR_OPT:  st_d.opt   = wr_data;
                default:   st_d       = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch = st_q.latch;
    assign dir   = st_q.dir;
    assign opt   = st_q.opt;
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
    parameter int N_PINS = 8
) (
    input  logic [N_PINS-1:0] latch,
    input  logic [N_PINS-1:0] dir,
    input  logic [N_PINS-1:0] opt,
    input  logic [N_PINS-1:0] pad_in,
    input  logic [N_PINS-1:0] alt_out_en,
    input  logic [N_PINS-1:0] alt_out_val,
    input  logic [N_PINS-1:0] alt_out_od,
    input  logic [N_PINS-1:0] alt_in_en,
    output logic [N_PINS-1:0] pad_oe,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_pu,
    output logic [N_PINS-1:0] pin_rd
);
    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        always_comb begin
            pad_oe[i]  = 1'b0;
            pad_out[i] = 1'b0;
            pad_pu[i]  = 1'b0;
            pin_rd[i]  = pad_in[i];
            if (alt_out_en[i]) begin
                pad_oe[i]  = alt_out_od[i] ? ~alt_out_val[i] : 1'b1;
                pad_out[i] = alt_out_od[i] ? 1'b0 : alt_out_val[i];
            end else if (alt_in_en[i]) begin
                pin_rd[i]  = pad_in[i];
            end else if (dir[i]) begin
                pad_oe[i]  = opt[i] ? ~latch[i] : 1'b1;
                pad_out[i] = opt[i] ? 1'b0 : latch[i];
                pin_rd[i]  = latch[i];
            end else begin
                pad_pu[i]  = opt[i];
            end
        end
    end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pad_in,
    input  logic [N_PINS-1:0] grp_pins,
    input  logic              grp_mask,
    input  logic [1:0]        mode,
    output logic              irq_req
);
    import gpio_pkg::*;

    typedef struct packed {
        logic [N_PINS-1:0] sync1;
        logic [N_PINS-1:0] sync2;
        logic              lvl_prev;
        logic              irq;
    } irq_t;

    irq_t st_d, st_q;
    logic grp_lvl, grp_active, fall, rise, hit;
    irq_mode_e mode_e;

    always_comb begin
        mode_e     = irq_mode_e'(mode);
        grp_lvl    = &(st_q.sync2 | ~grp_pins);
        grp_active = (|grp_pins) & ~grp_mask;
        fall       = st_q.lvl_prev & ~grp_lvl;
        rise       = ~st_q.lvl_prev & grp_lvl;
        case (mode_e)
            IRQ_LOW:  hit = ~grp_lvl;
            IRQ_FALL: hit = fall;
            IRQ_RISE: hit = rise;
            default:  hit = fall | rise;
        endcase
        st_d          = st_q;
        st_d.sync1    = pad_in;
        st_d.sync2    = st_q.sync1;
        st_d.lvl_prev = grp_lvl;
        st_d.irq      = grp_active & hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.lvl_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_req = st_q.irq;
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [N_PINS-1:0] wr_data,
    output logic [N_PINS-1:0] rd_data,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_oe,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_pu,
    input  logic [N_PINS-1:0] alt_out_en,
    input  logic [N_PINS-1:0] alt_out_val,
    input  logic [N_PINS-1:0] alt_out_od,
    input  logic [N_PINS-1:0] alt_in_en,
    input  logic [1:0]        irq_mode,
    output logic              irq_req
);
    import gpio_pkg::*;

    logic [N_PINS-1:0] latch, dir, opt, pin_rd, grp_pins;
    logic              grp_mask;

    gpio_regs #(.N_PINS(N_PINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .latch(latch), .dir(dir), .opt(opt)
    );

    gpio_pad_ctrl #(.N_PINS(N_PINS)) u_pads (
        .latch(latch), .dir(dir), .opt(opt), .pad_in(pad_in),
        .alt_out_en(alt_out_en), .alt_out_val(alt_out_val),
        .alt_out_od(alt_out_od), .alt_in_en(alt_in_en),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pin_rd(pin_rd)
    );

    // group membership and override masking
    assign grp_pins = ~dir & opt;
    assign grp_mask = |(grp_pins & (alt_in_en | alt_out_en));

    gpio_irq #(.N_PINS(N_PINS)) u_irq (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .grp_pins(grp_pins),
        .grp_mask(grp_mask), .mode(irq_mode), .irq_req(irq_req)
    );

    always_comb begin
        case (addr)
            ADDR_DATA: rd_data = pin_rd;
            ADDR_DIR:  rd_data = dir;
            ADDR_OPT:  rd_data = opt;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int N_PINS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_PINS-1:0] latch,
    input logic [N_PINS-1:0] dir,
    input logic [N_PINS-1:0] opt,
    input logic [N_PINS-1:0] pad_oe,
    input logic [N_PINS-1:0] pad_out,
    input logic [N_PINS-1:0] pad_pu,
    input logic [N_PINS-1:0] alt_out_en,
    input logic [N_PINS-1:0] alt_in_en,
    input logic [1:0]        irq_mode,
    input logic              irq_req
);
    a_r3_input_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        (~dir & ~alt_out_en & pad_oe) == '0);

    a_r4_pushpull_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (dir & ~opt & ~alt_out_en & ~alt_in_en & (pad_out ^ latch)) == '0);

    a_r5_opendrain_no_high: assert property (@(posedge clk) disable iff (!rst_n)
        (dir & opt & ~alt_out_en & ~alt_in_en & pad_out) == '0);

    a_r6_pullup_inputs_only: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & (dir | ~opt)) == '0);

    a_r8_alt_in_floating: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_in_en & ~alt_out_en & (pad_oe | pad_pu)) == '0);

    a_r9_empty_group_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((~dir & opt) == '0) |=> !irq_req);

    a_r11_fall_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode == 2'd1 && irq_req) |=> (!irq_req || irq_mode != 2'd1));

    a_r12_override_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (((~dir & opt) & (alt_in_en | alt_out_en)) != '0) |=> !irq_req);
endmodule

bind gpio_port gpio_port_chk #(.N_PINS(N_PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .latch(latch), .dir(dir), .opt(opt),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
    .alt_out_en(alt_out_en), .alt_in_en(alt_in_en),
    .irq_mode(irq_mode), .irq_req(irq_req)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [7:0] pad_in = 8'hFF;
    logic [7:0] pad_oe, pad_out, pad_pu;
    logic [7:0] alt_out_en = 8'h00, alt_out_val = 8'h00, alt_out_od = 8'h00, alt_in_en = 8'h00;
    logic [1:0] irq_mode = 2'd0;
    logic       irq_req;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    gpio_port u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pu(pad_pu), .alt_out_en(alt_out_en), .alt_out_val(alt_out_val),
        .alt_out_od(alt_out_od), .alt_in_en(alt_in_en), .irq_mode(irq_mode),
        .irq_req(irq_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic idle_cfg();
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h00);
        @(negedge clk);
        pad_in = 8'hFF; alt_in_en = 8'h00; alt_out_en = 8'h00; irq_mode = 2'd0;
        edges(4);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd1, v); chk("R1 dir", v, 8'h00);
        rd(2'd2, v); chk("R1 opt", v, 8'h00);
        chk("R1 oe", pad_oe, 8'h00);
        chk("R1 pu", pad_pu, 8'h00);
        chk("R1 irq", {7'd0, irq_req}, 8'h00);
    endtask

    task automatic t_regmap();
        logic [7:0] v;
        wr(2'd1, 8'hA5); wr(2'd2, 8'h3C);
        rd(2'd1, v); chk("R2 dir readback", v, 8'hA5);
        rd(2'd2, v); chk("R2 opt readback", v, 8'h3C);
        wr(2'd3, 8'hFF);
        rd(2'd3, v); chk("R2 addr3 reads zero", v, 8'h00);
        rd(2'd1, v); chk("R2 addr3 write ignored dir", v, 8'hA5);
        rd(2'd2, v); chk("R2 addr3 write ignored opt", v, 8'h3C);
        idle_cfg();
    endtask

    task automatic t_input_latch();
        logic [7:0] v;
        @(negedge clk) pad_in = 8'h5A;
        wr(2'd0, 8'hC3);
        rd(2'd0, v); chk("R3 input reads pin", v, 8'h5A);
        chk("R3 input undriven", pad_oe, 8'h00);
        wr(2'd1, 8'hFF);
        chk("R4 latch drives after switch", pad_out, 8'hC3);
        chk("R4 pushpull oe", pad_oe, 8'hFF);
        rd(2'd0, v); chk("R4 output reads latch", v, 8'hC3);
        chk("R6 no pullup on output", pad_pu, 8'h00);
    endtask

    task automatic t_opendrain();
        wr(2'd2, 8'hFF);
        chk("R5 od oe", pad_oe, 8'h3C);
        chk("R5 od out", pad_out, 8'h00);
        wr(2'd1, 8'h00);
        chk("R6 input opt pullup", pad_pu, 8'hFF);
        wr(2'd2, 8'h0F);
        chk("R6 floating input no pullup", pad_pu, 8'h0F);
        idle_cfg();
    endtask

    task automatic t_alt();
        logic [7:0] v;
        wr(2'd0, 8'h00); wr(2'd1, 8'hF0); wr(2'd2, 8'h0F);
        @(negedge clk);
        alt_out_en = 8'h11; alt_out_val = 8'h11; alt_out_od = 8'h10; alt_in_en = 8'h03;
        pad_in = 8'h02;
        #1;
        chk("R7 alt out oe", pad_oe & 8'h11, 8'h01);
        chk("R7 alt out val", pad_out & 8'h11, 8'h01);
        chk("R7 alt out no pu", pad_pu & 8'h11, 8'h00);
        chk("R8 alt in floating oe", pad_oe & 8'h02, 8'h00);
        chk("R8 alt in no pu", pad_pu & 8'h02, 8'h00);
        rd(2'd0, v); chk("R8 alt in reads pin", v & 8'h02, 8'h02);
        @(negedge clk) alt_out_en = 8'h00; alt_in_en = 8'h00; alt_out_od = 8'h00;
        idle_cfg();
    endtask

    task automatic t_irq_level();
        wr(2'd2, 8'h03);
        edges(4);
        chk("R10 no req all high", {7'd0, irq_req}, 8'h00);
        @(negedge clk) pad_in[1] = 1'b0;
        edges(2); chk("R10 not yet on edge2", {7'd0, irq_req}, 8'h00);
        edges(1); chk("R10 req on edge3", {7'd0, irq_req}, 8'h01);
        edges(3); chk("R10 level held", {7'd0, irq_req}, 8'h01);
        @(negedge clk) alt_in_en[0] = 1'b1;
        edges(1); chk("R12 alt in masks group", {7'd0, irq_req}, 8'h00);
        @(negedge clk) alt_in_en[0] = 1'b0; alt_out_en[1] = 1'b1;
        edges(1); chk("R12 alt out masks group", {7'd0, irq_req}, 8'h00);
        @(negedge clk) alt_out_en[1] = 1'b0;
        edges(1); chk("R10 req back after unmask", {7'd0, irq_req}, 8'h01);
        wr(2'd1, 8'h02);
        edges(1); chk("R9 output pin leaves group", {7'd0, irq_req}, 8'h00);
        idle_cfg();
        @(negedge clk) pad_in = 8'h00;
        edges(5); chk("R9 empty group quiet", {7'd0, irq_req}, 8'h00);
        idle_cfg();
    endtask

    task automatic t_irq_edges();
        wr(2'd2, 8'h03);
        @(negedge clk) irq_mode = 2'd1;
        edges(2);
        @(negedge clk) pad_in[0] = 1'b0;
        edges(3); chk("R11 fall pulse", {7'd0, irq_req}, 8'h01);
        edges(1); chk("R11 fall one cycle", {7'd0, irq_req}, 8'h00);
        @(negedge clk) pad_in[1] = 1'b0; pad_in[0] = 1'b1;
        edges(2);
        @(negedge clk) pad_in[0] = 1'b0;
        edges(4); chk("R9 low pin masks fall", {7'd0, irq_req}, 8'h00);
        @(negedge clk) irq_mode = 2'd2; pad_in[1] = 1'b1;
        edges(2);
        @(negedge clk) pad_in[0] = 1'b1;
        edges(3); chk("R11 rise pulse", {7'd0, irq_req}, 8'h01);
        edges(1); chk("R11 rise one cycle", {7'd0, irq_req}, 8'h00);
        @(negedge clk) irq_mode = 2'd3; pad_in[0] = 1'b0;
        edges(3); chk("R11 both fall", {7'd0, irq_req}, 8'h01);
        edges(1); chk("R11 both gap", {7'd0, irq_req}, 8'h00);
        @(negedge clk) pad_in[0] = 1'b1;
        edges(3); chk("R11 both rise", {7'd0, irq_req}, 8'h01);
        edges(1); chk("R11 both one cycle", {7'd0, irq_req}, 8'h00);
        idle_cfg();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_input_latch();
        t_opendrain();
        t_alt();
        t_irq_level();
        t_irq_edges();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule